// File: doc/BRIEF.md
# S/PDIF Channel Status Capture

This block collects the 192-bit channel status block carried in a decoded S/PDIF stream. An upstream biphase decoder presents one event per subframe: the channel-status bit of that subframe, a tag saying whether the subframe belongs to channel A or channel B, and a block-start flag that marks the first frame of a status block. A control input picks which of the two channels is captured. Bits of the chosen channel are gathered into a private shadow register. The register that software or neighbouring logic can read is updated only when all 192 bits of a block have arrived, so a reader never sees a half-written block.

The stored block is read as six 32-bit words through one read port steered by a 3-bit word select. The read is combinational and volatile: it can be sampled in any cycle, also while capture is running. The event input follows valid/ready rules. The block never applies back-pressure: ready is held high, so every cycle with valid high transfers exactly one subframe event.

Top module: `spdif_cs_capture`

## Requirements
- R1: After reset the stored block is all zero, so every word select reads 32'h0.
- R2: `ev_ready` is always 1; each cycle with `ev_valid` high consumes exactly one subframe event.
- R3: Only events whose tag `ev_chan_b` equals `src_b` (0 = channel A, 1 = channel B) take part in capture; events of the other channel leave the stored block unchanged.
- R4: A captured event with `ev_start` high restarts collection and its bit becomes status bit 0; captured events that arrive before any start are ignored.
- R5: Status bit k lands in byte k/8 at bit position k%8 (LSB first). Word w holds bytes 4w..4w+3, with byte 4w+j in bits 8j+7:8j of the read word.
- R6: The stored block changes only on the clock edge that accepts the 192nd bit of a block; the new words are on `rd_word` from that edge onward, and after 191 bits the old words are still shown.
- R7: A start before 192 bits have been collected throws away the partial block; the stored block keeps its previous value until a full block completes.
- R8: Word select values 6 and 7 read as 32'h0.
- R9: `rd_word` follows `rd_sel` in the same cycle, with no clock edge between them.
- R10: A change of `src_b` discards any partial block; bits of the newly chosen channel are ignored until that channel's next start.
- R11: After a block completes, further captured bits without a new start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_b | input | 1 | Captured channel: 0 = A, 1 = B |
| ev_valid | input | 1 | Subframe event present |
| ev_ready | output | 1 | Event accepted (always 1) |
| ev_cs_bit | input | 1 | Channel-status bit of the subframe |
| ev_chan_b | input | 1 | Subframe tag: 0 = A, 1 = B |
| ev_start | input | 1 | Subframe belongs to the first frame of a status block |
| rd_sel | input | 3 | Word select, 0..5 valid |
| rd_word | output | 32 | Selected status word |

## Verification
The stored block moves on the single edge that accepts bit 191, so the bench drives every event on a falling edge and reads the words on the following falling edge, one clock later, and also reads them after bit 190 to show that nothing moved early. Word selection has no register, so each read sets `rd_sel` and samples `rd_word` one nanosecond later in the same cycle. Ignored inputs (wrong channel, stray bits, a switch of channel, a restart) are judged by reading all six words after the stimulus and before the next block is sent.

// File: rtl/spdif_cs_pkg.sv
package spdif_cs_pkg;
  localparam int unsigned CS_BLK_BITS = 192;
  localparam int unsigned CS_WORD_W   = 32;
  localparam int unsigned CS_SEL_W    = 3;
  localparam int unsigned CS_NWORDS   = CS_BLK_BITS / CS_WORD_W;
  localparam int unsigned CS_CNT_W    = $clog2(CS_BLK_BITS);

  typedef struct packed {
    logic cs_bit;
    logic chan_b;
    logic start;
  } cs_event_t;
endpackage

// File: rtl/cs_bit_collector.sv
module cs_bit_collector #(
  parameter int unsigned BLK_BITS = 192,
  localparam int unsigned CNT_W   = $clog2(BLK_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                src_b,
  input  logic                ev_take,
  input  spdif_cs_pkg::cs_event_t ev,
  output logic                commit,
  output logic [BLK_BITS-1:0] full_blk
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLK_BITS - 1);

  logic [BLK_BITS-1:0] shadow_q;
  logic [CNT_W-1:0]    pos_q;
  logic                armed_q;
  logic                src_q;
  logic                src_chg;
  logic                hit;

  assign src_chg = (src_b != src_q);
  assign hit     = ev_take && (ev.chan_b == src_b) && !src_chg;
  assign commit  = hit && !ev.start && armed_q && (pos_q == LAST);

  always_comb begin
    full_blk       = shadow_q;
    full_blk[LAST] = ev.cs_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow_q <= '0;
      pos_q    <= '0;
      armed_q  <= 1'b0;
      src_q    <= 1'b0;
    end else begin
      src_q <= src_b;
      if (src_chg) begin
        armed_q <= 1'b0;
        pos_q   <= '0;
      end else if (hit) begin
        if (ev.start) begin
          shadow_q[0] <= ev.cs_bit;
          pos_q       <= CNT_W'(1);
          armed_q     <= 1'b1;
        end else if (armed_q) begin
          shadow_q[pos_q] <= ev.cs_bit;
          if (pos_q == LAST) begin
            pos_q   <= '0;
            armed_q <= 1'b0;
          end else begin
            pos_q <= pos_q + CNT_W'(1);
          end
        end
      end
    end
  end

  AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ev.start) |=> (armed_q && pos_q == CNT_W'(1))); // R4
  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (pos_q <= LAST)); // R6
  AST_IDLE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !armed_q); // R11
  AST_SRC_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    src_chg |=> !armed_q); // R10
endmodule

// File: rtl/cs_block_store.sv
module cs_block_store #(
  parameter int unsigned BLK_BITS = 192
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                commit,
  input  logic [BLK_BITS-1:0] full_blk,
  output logic [BLK_BITS-1:0] blk_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      blk_q <= '0;
    else if (commit) blk_q <= full_blk;
  end

  AST_HOLD_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(commit) |-> $stable(blk_q)); // R7
endmodule

// File: rtl/cs_word_mux.sv
module cs_word_mux #(
  parameter int unsigned BLK_BITS = 192,
  parameter int unsigned WORD_W   = 32,
  parameter int unsigned SEL_W    = 3,
  localparam int unsigned NWORDS  = BLK_BITS / WORD_W
) (
  input  logic [BLK_BITS-1:0] blk,
  input  logic [SEL_W-1:0]    sel,
  output logic [WORD_W-1:0]   word
);
  logic [WORD_W-1:0] words [NWORDS];

  for (genvar w = 0; w < NWORDS; w++) begin : g_slice
    assign words[w] = blk[w*WORD_W +: WORD_W];
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NWORDS; i++) begin
      if (sel == SEL_W'(i)) word = words[i];
    end
  end
endmodule

// File: rtl/spdif_cs_capture.sv
module spdif_cs_capture
  import spdif_cs_pkg::*;
#(
  parameter int unsigned BLK_BITS = CS_BLK_BITS,
  parameter int unsigned WORD_W   = CS_WORD_W,
  parameter int unsigned SEL_W    = CS_SEL_W,
  localparam int unsigned NWORDS  = BLK_BITS / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_b,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic              ev_cs_bit,
  input  logic              ev_chan_b,
  input  logic              ev_start,
  input  logic [SEL_W-1:0]  rd_sel,
  output logic [WORD_W-1:0] rd_word
);
  cs_event_t           ev;
  logic                commit;
  logic [BLK_BITS-1:0] full_blk;
  logic [BLK_BITS-1:0] blk_q;

  assign ev_ready = 1'b1;
  assign ev = '{cs_bit: ev_cs_bit, chan_b: ev_chan_b, start: ev_start};

  cs_bit_collector #(.BLK_BITS(BLK_BITS)) u_coll (
    .clk(clk), .rst_n(rst_n), .src_b(src_b),
    .ev_take(ev_valid && ev_ready), .ev(ev),
    .commit(commit), .full_blk(full_blk)
  );

  cs_block_store #(.BLK_BITS(BLK_BITS)) u_store (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .full_blk(full_blk), .blk_q(blk_q)
  );

  cs_word_mux #(.BLK_BITS(BLK_BITS), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_mux (
    .blk(blk_q), .sel(rd_sel), .word(rd_word)
  );

  AST_SEL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sel >= SEL_W'(NWORDS)) |-> (rd_word == '0)); // R8
endmodule

// File: tb/sim_spdif_cs_capture.sv
module sim_spdif_cs_capture;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_b = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic        ev_cs_bit = 1'b0;
  logic        ev_chan_b = 1'b0;
  logic        ev_start = 1'b0;
  logic [2:0]  rd_sel = 3'd0;
  logic [31:0] rd_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  spdif_cs_capture u0 (
    .clk(clk), .rst_n(rst_n), .src_b(src_b), .ev_valid(ev_valid),
    .ev_ready(ev_ready), .ev_cs_bit(ev_cs_bit), .ev_chan_b(ev_chan_b),
    .ev_start(ev_start), .rd_sel(rd_sel), .rd_word(rd_word)
  );

  function automatic logic pat(int seed, int k);
    if (seed == 0) return logic'(((k >> 3) >> (k % 8)) & 1);
    return logic'((((k * 7 + seed * 3) % 5) < 2) ^ ((k % seed) == 0));
  endfunction

  function automatic logic [31:0] exp_word(int seed, int w);
    logic [31:0] e;
    for (int b = 0; b < 32; b++) e[b] = (seed < 0) ? 1'b0 : pat(seed, 32 * w + b);
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(int w, output logic [31:0] v);
    @(negedge clk);
    rd_sel = 3'(w);
    #1 v = rd_word;
  endtask

  // seed < 0 means the all-zero block; R9: sample in the select cycle
  task automatic check_block(string req, int seed);
    logic [31:0] v;
    for (int w = 0; w < 6; w++) begin
      rd(w, v);
      chk(req, v, exp_word(seed, w));
    end
  endtask

  task automatic send(logic b, logic ch, logic st);
    @(negedge clk);
    ev_valid = 1'b1; ev_cs_bit = b; ev_chan_b = ch; ev_start = st;
  endtask

  task automatic idle();
    @(negedge clk);
    ev_valid = 1'b0; ev_start = 1'b0;
  endtask

  task automatic send_ab(int sa, int sb, int from, int to);
    for (int k = from; k <= to; k++) begin
      send(pat(sa, k), 1'b0, k == 0);
      send(pat(sb, k), 1'b1, k == 0);
    end
    idle();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int w = 0; w < 8; w++) begin
      rd(w, v);
      chk("R1", v, 32'h0);
    end
    chk("R2", {31'b0, ev_ready}, 32'h1);
    send_ab(1, 2, 5, 191);               // no start: R4 bits ignored
    check_block("R4", -1);
  endtask

  task automatic t_full_a();
    logic [31:0] v;
    src_b = 1'b0;
    send_ab(3, 4, 0, 190);
    chk("R2", {31'b0, ev_ready}, 32'h1);
    rd(5, v);
    chk("R6", v, 32'h0);
    send_ab(3, 4, 191, 191);
    check_block("R3", 3);
  endtask

  task automatic t_byte_order();
    logic [31:0] v;
    send_ab(0, 4, 0, 191);
    rd(0, v); chk("R5", v, 32'h03020100);
    rd(3, v); chk("R5", v, 32'h0f0e0d0c);
    rd(5, v); chk("R5", v, 32'h17161514);
    rd(2, v); chk("R9", v, 32'h0b0a0908);
  endtask

  task automatic t_restart();
    send_ab(5, 6, 0, 99);
    send_ab(7, 6, 0, 120);
    check_block("R7", 0);
    send_ab(7, 6, 121, 191);
    check_block("R7", 7);
  endtask

  task automatic t_sel_high();
    logic [31:0] v;
    rd(6, v); chk("R8", v, 32'h0);
    rd(7, v); chk("R8", v, 32'h0);
  endtask

  task automatic t_src_b();
    @(negedge clk); src_b = 1'b1;
    idle();
    send_ab(9, 10, 0, 191);
    check_block("R3", 10);
  endtask

  task automatic t_src_switch();
    @(negedge clk); src_b = 1'b0;
    idle();
    send_ab(11, 12, 0, 50);
    @(negedge clk); src_b = 1'b1;
    idle();
    send_ab(11, 12, 51, 191);
    check_block("R10", 10);
  endtask

  task automatic t_after_full();
    send_ab(13, 14, 0, 191);
    check_block("R11", 14);
    send_ab(15, 16, 1, 191);
    check_block("R11", 14);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_full_a();
    t_byte_order();
    t_restart();
    t_sel_high();
    t_src_b();
    t_src_switch();
    t_after_full();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule